// File: doc/BRIEF.md
# Dual-Master Shared Memory Arbiter

This block lets two masters share one memory port that accepts a single-cycle access per clock. One master is a video fetcher that reads pattern data. The other is a program master that reads and writes. Both masters drive strobes that are not related to the arbiter clock, so each strobe passes through its own flop chain before any logic uses it. On a synchronized rising edge, the master's address, direction and write data go into a request latch. The latch clears once the access has been granted.

One slot goes out per cycle. A pending video read always goes first, then a pending refresh, then the program access. The program master is held off with a wait output until its access has finished, and nothing is dropped. A free-running counter raises a refresh request at a fixed interval. The memory port is registered. The memory returns read data in the cycle after the issue cycle, and the arbiter registers that data on the master's data bus one cycle later.

Top module: `memShareArbiter`

## Requirements
- R1: While reset is active and after it is released with no traffic, memEn, memRefresh, prgWait and vidValid are all 0.
- R2: A video strobe first sampled high at clock edge k+1 produces a memory read at edge k+SYNC_STAGES+2. Its data is on vidData with vidValid=1 after edge k+SYNC_STAGES+4, when no slot is competing.
- R3: A video read drives memAddr = {1'b1, vidAddr} and a program access drives memAddr = {1'b0, prgAddr}. vidData and prgRdata equal the memory word at that address.
- R4: When the video and program request latches are both set in the same cycle, the video read is issued first and the program access in the next cycle.
- R5: For a program strobe first sampled at edge k+1, prgWait is 1 from edge k+SYNC_STAGES+1. It returns to 0 exactly two edges after its memory issue, in the same cycle that read data becomes valid on prgRdata.
- R6: A program write (prgWr strobe) issues memWe=1 with memAddr={1'b0,prgAddr} and memWdata=prgWdata. Its prgWait falls two edges after the issue. A later read of that address returns the written value.
- R7: With no competing request, memRefresh is a one-cycle pulse every REF_INTERVAL cycles, and memEn is 0 in that cycle.
- R8: A refresh request ranks below a video read and above a program access. When all three are latched in the same cycle, the port order is video, refresh, program on consecutive cycles. A refresh is never deferred by more than 2 cycles.
- R9: In no cycle are both memEn and memRefresh asserted.
- R10: Each program strobe produces exactly one memory access with memAddr[AW-1]=0. A pending program request is never dropped.
- R11: vidValid falls at edge k+SYNC_STAGES+1 when a new video strobe is latched, and it rises again when that read's data lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rstN | input | 1 | Active-low synchronous reset |
| vidRd | input | 1 | Video read strobe, asynchronous |
| vidAddr | input | AW-1 | Video read address, stable while the strobe is high |
| vidData | output | DW | Last video read data |
| vidValid | output | 1 | vidData holds the data of the latest video request |
| prgRd | input | 1 | Program read strobe, asynchronous |
| prgWr | input | 1 | Program write strobe, asynchronous |
| prgAddr | input | AW-1 | Program address |
| prgWdata | input | DW | Program write data |
| prgRdata | output | DW | Last program read data |
| prgWait | output | 1 | Stall for the program master |
| memEn | output | 1 | Memory access this cycle |
| memWe | output | 1 | Access is a write |
| memAddr | output | AW | Memory address |
| memWdata | output | DW | Memory write data |
| memRefresh | output | 1 | Refresh slot this cycle |
| memRdata | input | DW | Memory read data, valid the cycle after memEn |

## Verification
Any error in the request latches or in the slot order shows at the ports within two or three cycles of the strobe being synchronized:
- a lost or duplicated program request changes the count of low-half accesses, or leaves prgWait stuck high;
- a wrong priority moves the video or program issue cycle by one;
- a broken refresh counter changes the spacing between memRefresh pulses on the next interval.

The bench sweeps the skew between the two masters' strobes across every relative cycle near a collision. It also lines a video read and a program read up exactly onto a refresh request. Each issue cycle and each data-valid cycle is compared with its arithmetic expectation.

// File: rtl/memShareArbPkg.sv
package memShareArbPkg;

  // One-cycle grant strobes from control to datapath
  typedef struct packed {
    logic issueVid;
    logic issueRef;
    logic issuePrg;
  } slotStrobeT;

  // Index of each asynchronous strobe in the synchronizer bank
  localparam int STB_VID = 0;
  localparam int STB_PRD = 1;
  localparam int STB_PWR = 2;
  localparam int STB_NUM = 3;

endpackage

// File: rtl/strobeSync.sv
module strobeSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              lastLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain   <= '0;
      lastLvl <= 1'b0;
    end else begin
      chain[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      lastLvl <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~lastLvl;

  // A rising edge is a single-cycle pulse
  a_r2_rise_single: assert property (@(posedge clk) disable iff (!rstN)
    rise |=> !rise);
endmodule

// File: rtl/arbCtrl.sv
module arbCtrl
  import memShareArbPkg::*;
#(
  parameter int REF_INTERVAL = 1560,
  parameter int REF_MAX_DEFER = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vidPend,
  input  logic       prgPend,
  output slotStrobeT slot
);
  localparam int CW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam int AGE_W = $clog2(REF_MAX_DEFER + 2);

  logic [CW-1:0]    refCnt;
  logic             refPend;
  logic [AGE_W-1:0] refAge;
  logic             refTick;

  assign refTick = (refCnt == CW'(REF_INTERVAL - 1));

  // Interval counter: free-running, independent of grants
  always_ff @(posedge clk) begin
    if (!rstN) refCnt <= '0;
    else if (refTick) refCnt <= '0;
    else refCnt <= refCnt + 1'b1;
  end

  // Refresh request latch and its deferral age
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPend <= 1'b0;
      refAge  <= '0;
    end else begin
      if (refTick) refPend <= 1'b1;
      else if (slot.issueRef) refPend <= 1'b0;
      if (refPend && !slot.issueRef) refAge <= refAge + 1'b1;
      else refAge <= '0;
    end
  end

  // Fixed ranking: video, then refresh, then program
  always_comb begin
    slot.issueVid = vidPend;
    slot.issueRef = refPend & ~vidPend;
    slot.issuePrg = prgPend & ~vidPend & ~refPend;
  end

  // R8: refresh waits only a bounded number of cycles
  a_r8_refresh_bounded: assert property (@(posedge clk) disable iff (!rstN)
    refAge <= AGE_W'(REF_MAX_DEFER));

  // R10: a program request that loses arbitration is still pending next cycle
  a_r10_prg_held: assert property (@(posedge clk) disable iff (!rstN)
    (prgPend && vidPend) |=> prgPend);
endmodule

// File: rtl/arbDatapath.sv
module arbDatapath
  import memShareArbPkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          vidRise,
  input  logic          prgRdRise,
  input  logic          prgWrRise,
  input  logic [AW-2:0] vidAddr,
  input  logic [AW-2:0] prgAddr,
  input  logic [DW-1:0] prgWdata,
  input  slotStrobeT    slot,
  input  logic [DW-1:0] memRdata,
  output logic          vidPend,
  output logic          prgPend,
  output logic          memEn,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memRefresh,
  output logic [DW-1:0] vidData,
  output logic          vidValid,
  output logic [DW-1:0] prgRdata,
  output logic          prgWait
);
  logic          prgAnyRise;
  logic [AW-2:0] vidAddrQ, prgAddrQ;
  logic [DW-1:0] prgWdataQ;
  logic          prgIsWr;
  logic          issVidQ, issPrgRdQ, issPrgQ;
  logic          retVid, retPrgRd, retPrg;
  logic          prgBusy;

  assign prgAnyRise = prgRdRise | prgWrRise;

  // Video request latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vidPend  <= 1'b0;
      vidAddrQ <= '0;
    end else if (vidRise) begin
      vidPend  <= 1'b1;
      vidAddrQ <= vidAddr;
    end else if (slot.issueVid) begin
      vidPend <= 1'b0;
    end
  end

  // Program request latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prgPend   <= 1'b0;
      prgIsWr   <= 1'b0;
      prgAddrQ  <= '0;
      prgWdataQ <= '0;
    end else if (prgAnyRise) begin
      prgPend   <= 1'b1;
      prgIsWr   <= prgWrRise;
      prgAddrQ  <= prgAddr;
      prgWdataQ <= prgWdata;
    end else if (slot.issuePrg) begin
      prgPend <= 1'b0;
    end
  end

  // Registered memory port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memEn      <= 1'b0;
      memWe      <= 1'b0;
      memAddr    <= '0;
      memWdata   <= '0;
      memRefresh <= 1'b0;
      issVidQ    <= 1'b0;
      issPrgQ    <= 1'b0;
      issPrgRdQ  <= 1'b0;
    end else begin
      memEn      <= slot.issueVid | slot.issuePrg;
      memWe      <= slot.issuePrg & prgIsWr;
      memAddr    <= slot.issueVid ? {1'b1, vidAddrQ} : {1'b0, prgAddrQ};
      memWdata   <= prgWdataQ;
      memRefresh <= slot.issueRef;
      issVidQ    <= slot.issueVid;
      issPrgQ    <= slot.issuePrg;
      issPrgRdQ  <= slot.issuePrg & ~prgIsWr;
    end
  end

  // Return stage: memory data is valid the cycle after issue
  always_ff @(posedge clk) begin
    if (!rstN) begin
      retVid   <= 1'b0;
      retPrg   <= 1'b0;
      retPrgRd <= 1'b0;
    end else begin
      retVid   <= issVidQ;
      retPrg   <= issPrgQ;
      retPrgRd <= issPrgRdQ;
    end
  end

  // Capture onto the masters' data buses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vidData  <= '0;
      vidValid <= 1'b0;
      prgRdata <= '0;
      prgBusy  <= 1'b0;
    end else begin
      if (retVid) begin
        vidData  <= memRdata;
        vidValid <= 1'b1;
      end else if (vidRise) begin
        vidValid <= 1'b0;
      end
      if (retPrgRd) prgRdata <= memRdata;
      if (slot.issuePrg) prgBusy <= 1'b1;
      else if (retPrg) prgBusy <= 1'b0;
    end
  end

  assign prgWait = prgPend | prgBusy;

  // R5: stall is raised the cycle after the synchronized strobe edge
  a_r5_wait_after_rise: assert property (@(posedge clk) disable iff (!rstN)
    prgAnyRise |=> prgWait);

  // R10: a pending program request survives until it is granted
  a_r10_no_drop: assert property (@(posedge clk) disable iff (!rstN)
    (prgPend && !slot.issuePrg && !prgAnyRise) |=> prgPend);

  // R3: a video grant lands as an upper-half read on the port
  a_r3_vid_upper: assert property (@(posedge clk) disable iff (!rstN)
    slot.issueVid |=> (memEn && !memWe && memAddr[AW-1]));
endmodule

// File: rtl/memShareArbiter.sv
module memShareArbiter
  import memShareArbPkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter int REF_INTERVAL = 1560
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          vidRd,
  input  logic [AW-2:0] vidAddr,
  output logic [DW-1:0] vidData,
  output logic          vidValid,
  input  logic          prgRd,
  input  logic          prgWr,
  input  logic [AW-2:0] prgAddr,
  input  logic [DW-1:0] prgWdata,
  output logic [DW-1:0] prgRdata,
  output logic          prgWait,
  output logic          memEn,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memRefresh,
  input  logic [DW-1:0] memRdata
);
  logic [STB_NUM-1:0] strobeIn, strobeRise;
  logic               vidPend, prgPend;
  slotStrobeT         slot;

  assign strobeIn[STB_VID] = vidRd;
  assign strobeIn[STB_PRD] = prgRd;
  assign strobeIn[STB_PWR] = prgWr;

  for (genvar g = 0; g < STB_NUM; g++) begin : gSync
    strobeSync #(.STAGES(SYNC_STAGES)) uSync (
      .clk(clk), .rstN(rstN), .asyncIn(strobeIn[g]), .rise(strobeRise[g])
    );
  end

  arbCtrl #(.REF_INTERVAL(REF_INTERVAL)) uCtrl (
    .clk(clk), .rstN(rstN), .vidPend(vidPend), .prgPend(prgPend), .slot(slot)
  );

  arbDatapath #(.AW(AW), .DW(DW)) uDp (
    .clk(clk), .rstN(rstN),
    .vidRise(strobeRise[STB_VID]), .prgRdRise(strobeRise[STB_PRD]),
    .prgWrRise(strobeRise[STB_PWR]),
    .vidAddr(vidAddr), .prgAddr(prgAddr), .prgWdata(prgWdata),
    .slot(slot), .memRdata(memRdata),
    .vidPend(vidPend), .prgPend(prgPend),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRefresh(memRefresh),
    .vidData(vidData), .vidValid(vidValid), .prgRdata(prgRdata), .prgWait(prgWait)
  );

  // R9: a refresh slot never coincides with a data access
  a_r9_single_slot: assert property (@(posedge clk) disable iff (!rstN)
    !(memEn && memRefresh));

  // R4: with both latches set, the next port cycle serves video
  a_r4_vid_first: assert property (@(posedge clk) disable iff (!rstN)
    (vidPend && prgPend) |=> (memEn && memAddr[AW-1]));

  // R7: refresh is a single-cycle pulse
  a_r7_refresh_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memRefresh |=> !memRefresh);
endmodule

// File: tb/tb_memShareArbiter.sv
`timescale 1ns/1ps
module tb_memShareArbiter;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NS = 2;
  localparam int RI = 40;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          vidRd = 1'b0, prgRd = 1'b0, prgWr = 1'b0;
  logic [AW-2:0] vidAddr = '0, prgAddr = '0;
  logic [DW-1:0] prgWdata = '0;
  logic [DW-1:0] vidData, prgRdata, memWdata;
  logic          vidValid, prgWait, memEn, memWe, memRefresh;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memRdata = '0;

  memShareArbiter #(.AW(AW), .DW(DW), .SYNC_STAGES(NS), .REF_INTERVAL(RI)) dut (
    .clk(clk), .rstN(rstN), .vidRd(vidRd), .vidAddr(vidAddr), .vidData(vidData),
    .vidValid(vidValid), .prgRd(prgRd), .prgWr(prgWr), .prgAddr(prgAddr),
    .prgWdata(prgWdata), .prgRdata(prgRdata), .prgWait(prgWait),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRefresh(memRefresh), .memRdata(memRdata)
  );

  function automatic logic [DW-1:0] initWord(int a);
    return DW'((a * 7 + 3) & 8'hFF);
  endfunction

  // Memory model: registered read, one cycle after memEn
  logic [DW-1:0] mem [0:(1<<AW)-1];
  initial for (int i = 0; i < (1 << AW); i++) mem[i] = initWord(i);
  always @(posedge clk) if (memEn) begin
    if (memWe) mem[memAddr] <= memWdata;
    else memRdata <= mem[memAddr];
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChk = 0, nFail = 0, overlapCnt = 0, prgAccCnt = 0, prgReqCnt = 0;
  int lastVidIss = -1, lastPrgIss = -1, lastWrCyc = -1, lastRefCyc = -1;
  logic [AW-1:0] lastWrAddr = '0;
  logic [DW-1:0] lastWrData = '0;
  bit done = 0;

  always @(negedge clk) if (rstN) begin
    if (memEn && memRefresh) overlapCnt++;
    if (memRefresh) lastRefCyc = cyc;
    if (memEn && memAddr[AW-1]) lastVidIss = cyc;
    if (memEn && !memAddr[AW-1]) begin
      prgAccCnt++;
      lastPrgIss = cyc;
      if (memWe) begin
        lastWrCyc = cyc; lastWrAddr = memAddr; lastWrData = memWdata;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic waitRefresh(output int x);
    do @(negedge clk); while (!memRefresh);
    x = cyc;
  endtask

  int vFall, vRise, wRise, wFall;

  // Drive strobes from negedge kv / kp for 6 cycles (negative: unused), run to endC
  task automatic traffic(int kv, int kp, bit isWr, int endC);
    vFall = -1; vRise = -1; wRise = -1; wFall = -1;
    if (kp >= 0) prgReqCnt++;
    while (cyc < endC) begin
      @(negedge clk);
      vidRd = (kv >= 0) && (cyc >= kv) && (cyc < kv + 6);
      prgRd = !isWr && (kp >= 0) && (cyc >= kp) && (cyc < kp + 6);
      prgWr = isWr && (kp >= 0) && (cyc >= kp) && (cyc < kp + 6);
      if (kv >= 0 && cyc > kv && !vidValid && vFall < 0) vFall = cyc;
      if (vFall >= 0 && vRise < 0 && vidValid) vRise = cyc;
      if (kp >= 0 && prgWait && wRise < 0) wRise = cyc;
      if (wRise >= 0 && !prgWait && wFall < 0) wFall = cyc;
    end
    vidRd = 0; prgRd = 0; prgWr = 0;
  endtask

  initial begin
    int x, x2, kv, kp, iv, ip;
    repeat (4) @(negedge clk);
    chk("R1 reset memEn", int'(memEn), 0);
    chk("R1 reset prgWait", int'(prgWait), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle memEn", int'(memEn), 0);
    chk("R1 idle memRefresh", int'(memRefresh), 0);
    chk("R1 idle prgWait", int'(prgWait), 0);
    chk("R1 idle vidValid", int'(vidValid), 0);

    // R7: uncontested refresh spacing and empty data slot
    waitRefresh(x);
    for (int n = 0; n < 3; n++) begin
      waitRefresh(x2);
      chk("R7 refresh interval", x2 - x, RI);
      chk("R7 no access in refresh slot", int'(memEn), 0);
      x = x2;
    end

    // R2/R3: video read address sweep
    for (int i = 0; i < 8; i++) begin
      waitRefresh(x);
      vidAddr = (AW-1)'((i * 37 + 5) % (1 << (AW - 1)));
      kv = x + 2;
      traffic(kv, -1, 0, x + 20);
      chk("R2 video issue cycle", lastVidIss, kv + NS + 2);
      chk("R2 video data valid cycle", vRise, kv + NS + 4);
      chk("R11 vidValid fall cycle", vFall, (i == 0) ? kv + 1 : kv + NS + 1);
      chk("R3 video data", int'(vidData), int'(initWord((1 << (AW - 1)) + int'(vidAddr))));
    end

    // R4/R5: skew sweep of video against program strobes
    for (int s = -3; s <= 3; s++) begin
      waitRefresh(x);
      vidAddr = (AW-1)'(10 + s + 3);
      prgAddr = (AW-1)'(20 + 2 * (s + 3));
      kv = x + 6; kp = kv + s;
      traffic(kv, kp, 0, x + 24);
      iv = kv + NS + 2;
      ip = (kp + NS + 2 == iv) ? iv + 1 : kp + NS + 2;
      chk("R4 video issue cycle", lastVidIss, iv);
      chk("R4 program issue cycle", lastPrgIss, ip);
      chk("R2 video data valid", vRise, kv + NS + 4);
      chk("R11 vidValid fall", vFall, kv + NS + 1);
      chk("R5 prgWait rise", wRise, kp + NS + 1);
      chk("R5 prgWait fall", wFall, ip + 2);
      chk("R3 program data", int'(prgRdata), int'(initWord(int'(prgAddr))));
      chk("R3 video data", int'(vidData), int'(initWord((1 << (AW - 1)) + int'(vidAddr))));
    end

    // R8: video, refresh and program latched in the same cycle
    waitRefresh(x);
    vidAddr = 7'd99; prgAddr = 7'd55;
    kv = x + RI - NS - 2; kp = kv;
    traffic(kv, kp, 0, x + RI + 10);
    chk("R8 video first", lastVidIss, x + RI);
    chk("R8 refresh second", lastRefCyc, x + RI + 1);
    chk("R8 program third", lastPrgIss, x + RI + 2);
    chk("R8 program wait fall", wFall, x + RI + 4);
    chk("R8 program data", int'(prgRdata), int'(initWord(55)));

    // R6: program write then read-back
    waitRefresh(x);
    prgAddr = 7'd77; prgWdata = 8'hA5;
    kp = x + 2;
    traffic(-1, kp, 1, x + 18);
    chk("R6 write issue cycle", lastWrCyc, kp + NS + 2);
    chk("R6 write address", int'(lastWrAddr), 77);
    chk("R6 write data", int'(lastWrData), 8'hA5);
    chk("R6 write wait fall", wFall, kp + NS + 4);
    waitRefresh(x);
    kp = x + 2;
    traffic(-1, kp, 0, x + 18);
    chk("R6 read-back data", int'(prgRdata), 8'hA5);
    chk("R5 read wait fall", wFall, kp + NS + 4);

    repeat (4) @(negedge clk);
    chk("R9 no access during refresh", overlapCnt, 0);
    chk("R10 one access per program strobe", prgAccCnt, prgReqCnt);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      done = 1;
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end
endmodule